// File: doc/BRIEF.md
# Converter Output Test Word Generator

This block picks the sample word that a converter data path hands on toward its serial link. In normal use it forwards the live converter sample and that sample's valid strobe. A 4-bit mode code can replace the live data with a synthetic pattern: constant all-zero or all-one words, a two-word bit-alternating toggle, a free-running up-counter ramp, one programmable word repeated, two programmable words in alternation, a fixed deskew word and a fixed sync word. These patterns let the receiver side test lane alignment and data integrity without an analog input.

One word leaves the block on every clock, from a single output register. The two programmable words come in as plain inputs from whatever register file owns them. Sequenced patterns (toggle, ramp, alternation) always restart from their first word when their mode is entered, so the receiver can predict the stream.

Top module: `tpg_top`

## Requirements
- R1: With mode code 0000 the output word and output valid equal the live sample and live strobe presented one clock earlier.
- R2: Mode code 0001 gives the word 0x0000 and mode code 0010 gives the word 0x3FFF.
- R3: Mode code 0011 gives 0x2AAA on the first clock after the mode is entered, then alternates with 0x1555 on every clock.
- R4: Mode code 0100 gives 0x0000 on the first clock after the mode is entered, then adds one on every clock.
- R5: The ramp of mode 0100 steps from 0x3FFF straight to 0x0000 on the next clock.
- R6: Mode code 0110 gives the first programmable word on every clock.
- R7: Mode code 0111 gives the first programmable word on the first clock after the mode is entered, then alternates with the second programmable word on every clock, also when both words hold the same value (all zeros or all ones).
- R8: Mode code 1000 gives 0x2AAA and mode code 1001 gives 0x3FFF on every clock.
- R9: Mode codes 0101 and 1010 through 1111 behave exactly like mode code 0000.
- R10: While the active-low reset is low the output word is 0x0000 and the output valid is low; the first sequenced word after reset is the first word of its sequence.
- R11: In every test mode (codes 0001 to 0100 and 0110 to 1001) the output valid is high whatever the live strobe does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| mode_code | input | 4 | Pattern selection code |
| cust_word_a | input | 14 | First programmable pattern word |
| cust_word_b | input | 14 | Second programmable pattern word |
| live_data | input | 14 | Live converter sample |
| live_vld | input | 1 | Valid strobe of the live sample |
| out_data | output | 14 | Selected sample word |
| out_vld | output | 1 | Valid flag of the selected word |

## Verification
Every result of this block is due exactly one clock after the inputs that cause it: the mode code, programmable words and live sample seen at a rising edge appear at the outputs just after that edge. The bench drives all inputs on the falling edge, waits for one rising edge and samples on the next falling edge, so each check compares against the inputs of the previous half-period. Sequence starts are checked on the first word after each mode change, the ramp wrap is checked at the 16384th word, and reset is checked asynchronously while it is held low.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  // Internal source selection, decoded from the external mode code.
  typedef enum logic [3:0] {
    SRC_LIVE   = 4'd0,
    SRC_ZERO   = 4'd1,
    SRC_ONES   = 4'd2,
    SRC_TOGGLE = 4'd3,
    SRC_RAMP   = 4'd4,
    SRC_CUSTA  = 4'd5,
    SRC_ALT    = 4'd6,
    SRC_DESKEW = 4'd7,
    SRC_SYNC   = 4'd8
  } src_e;

  // Wide masks sliced down to the data width by the users.
  localparam logic [31:0] ODD_BITS_MASK  = 32'hAAAA_AAAA;
  localparam logic [31:0] EVEN_BITS_MASK = 32'h5555_5555;

endpackage

// File: rtl/tpg_mode_decode.sv
module tpg_mode_decode
  import tpg_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic [MODE_W-1:0] mode_code,
  output src_e              src_o,
  output logic              is_test_o
);

  always_comb begin
    case (mode_code)
      MODE_W'(4'b0001): src_o = SRC_ZERO;
      MODE_W'(4'b0010): src_o = SRC_ONES;
      MODE_W'(4'b0011): src_o = SRC_TOGGLE;
      MODE_W'(4'b0100): src_o = SRC_RAMP;
      MODE_W'(4'b0110): src_o = SRC_CUSTA;
      MODE_W'(4'b0111): src_o = SRC_ALT;
      MODE_W'(4'b1000): src_o = SRC_DESKEW;
      MODE_W'(4'b1001): src_o = SRC_SYNC;
      default:          src_o = SRC_LIVE;  // 0000 and every unused code
    endcase
  end

  assign is_test_o = (src_o != SRC_LIVE);

endmodule

// File: rtl/tpg_ramp.sv
module tpg_ramp #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              enter,
  output logic [DATA_W-1:0] ramp_val
);

  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] cnt_d;
  logic              cnt_en;

  // Next-state logic: on entry the word is zero, the stored count is the
  // word for the following clock. Natural wrap at the top code.
  always_comb begin
    ramp_val = enter ? '0 : cnt_q;
    cnt_en   = active;
    cnt_d    = ramp_val + DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !enter) |-> (ramp_val == DATA_W'($past(ramp_val) + 1'b1))); // R5

endmodule

// File: rtl/tpg_phase.sv
module tpg_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic enter,
  output logic second_word
);

  logic ph_q;
  logic ph_d;
  logic ph_en;

  always_comb begin
    second_word = enter ? 1'b0 : ph_q;
    ph_en       = active;
    ph_d        = ~second_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
    end else if (ph_en) begin
      ph_q <= ph_d;
    end
  end

  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !enter) |-> (second_word != $past(second_word))); // R7

endmodule

// File: rtl/tpg_top.sv
module tpg_top
  import tpg_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_code,
  input  logic [DATA_W-1:0] cust_word_a,
  input  logic [DATA_W-1:0] cust_word_b,
  input  logic [DATA_W-1:0] live_data,
  input  logic              live_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              out_vld
);

  localparam logic [DATA_W-1:0] WORD_TOG_A  = ODD_BITS_MASK[DATA_W-1:0];
  localparam logic [DATA_W-1:0] WORD_TOG_B  = EVEN_BITS_MASK[DATA_W-1:0];
  localparam logic [DATA_W-1:0] WORD_DESKEW = ODD_BITS_MASK[DATA_W-1:0];
  localparam logic [DATA_W-1:0] WORD_SYNC   = {DATA_W{1'b1}};

  src_e              src;
  src_e              src_q;
  logic              is_test;
  logic              enter;
  logic              ramp_on;
  logic              alt_on;
  logic [DATA_W-1:0] ramp_val;
  logic              second_word;
  logic [DATA_W-1:0] word_d;
  logic              vld_d;
  logic [DATA_W-1:0] word_q;
  logic              vld_q;

  tpg_mode_decode #(.MODE_W(MODE_W)) u_dec (
    .mode_code (mode_code),
    .src_o     (src),
    .is_test_o (is_test)
  );

  // Source seen on the previous clock; any difference is a mode entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_LIVE;
    end else begin
      src_q <= src;
    end
  end

  always_comb begin
    enter   = (src != src_q);
    ramp_on = (src == SRC_RAMP);
    alt_on  = (src == SRC_TOGGLE) || (src == SRC_ALT);
  end

  tpg_ramp #(.DATA_W(DATA_W)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (ramp_on),
    .enter    (enter),
    .ramp_val (ramp_val)
  );

  tpg_phase u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (alt_on),
    .enter       (enter),
    .second_word (second_word)
  );

  // Word selection.
  always_comb begin
    case (src)
      SRC_ZERO:   word_d = '0;
      SRC_ONES:   word_d = {DATA_W{1'b1}};
      SRC_TOGGLE: word_d = second_word ? WORD_TOG_B : WORD_TOG_A;
      SRC_RAMP:   word_d = ramp_val;
      SRC_CUSTA:  word_d = cust_word_a;
      SRC_ALT:    word_d = second_word ? cust_word_b : cust_word_a;
      SRC_DESKEW: word_d = WORD_DESKEW;
      SRC_SYNC:   word_d = WORD_SYNC;
      default:    word_d = live_data;
    endcase
    vld_d = is_test ? 1'b1 : live_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign out_data = word_q;
  assign out_vld  = vld_q;

  AST_PASS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == MODE_W'(0)) |=> (out_data == $past(live_data) && out_vld == $past(live_vld))); // R1
  AST_TEST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    is_test |=> out_vld); // R11
  AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == MODE_W'(1)) |=> (out_data == '0)); // R2
  AST_SYNC_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == MODE_W'(9)) |=> (out_data == WORD_SYNC)); // R8
  AST_RESET_OUT: assert property (@(posedge clk)
    !rst_n |-> (out_data == '0 && !out_vld)); // R10

endmodule

// File: tb/tpg_top_tb.sv
module tpg_top_tb;

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  mode;
    logic [13:0] ca;
    logic [13:0] cb;
    logic [13:0] live;
    logic        lv;
    logic [13:0] ed;
    logic        ev;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  4'h0, 14'h0000, 14'h0000, 14'h0123, 1'b1, 14'h0123, 1'b1}, // R1
    '{4'd1,  4'h0, 14'h0000, 14'h0000, 14'h3ABC, 1'b0, 14'h3ABC, 1'b0}, // R1
    '{4'd2,  4'h1, 14'h0000, 14'h0000, 14'h1111, 1'b0, 14'h0000, 1'b1}, // R2 R11
    '{4'd2,  4'h2, 14'h0000, 14'h0000, 14'h1111, 1'b0, 14'h3FFF, 1'b1}, // R2
    '{4'd3,  4'h3, 14'h0000, 14'h0000, 14'h0000, 1'b0, 14'h2AAA, 1'b1}, // R3
    '{4'd3,  4'h3, 14'h0000, 14'h0000, 14'h0000, 1'b0, 14'h1555, 1'b1}, // R3
    '{4'd3,  4'h3, 14'h0000, 14'h0000, 14'h0000, 1'b0, 14'h2AAA, 1'b1}, // R3
    '{4'd4,  4'h4, 14'h0000, 14'h0000, 14'h0000, 1'b0, 14'h0000, 1'b1}, // R4
    '{4'd4,  4'h4, 14'h0000, 14'h0000, 14'h0000, 1'b0, 14'h0001, 1'b1}, // R4
    '{4'd4,  4'h4, 14'h0000, 14'h0000, 14'h0000, 1'b1, 14'h0002, 1'b1}, // R4
    '{4'd6,  4'h6, 14'h1234, 14'h0F0F, 14'h0000, 1'b0, 14'h1234, 1'b1}, // R6
    '{4'd6,  4'h6, 14'h1234, 14'h0F0F, 14'h0000, 1'b0, 14'h1234, 1'b1}, // R6
    '{4'd7,  4'h7, 14'h0F0F, 14'h30F0, 14'h0000, 1'b0, 14'h0F0F, 1'b1}, // R7
    '{4'd7,  4'h7, 14'h0F0F, 14'h30F0, 14'h0000, 1'b0, 14'h30F0, 1'b1}, // R7
    '{4'd7,  4'h7, 14'h0F0F, 14'h30F0, 14'h0000, 1'b0, 14'h0F0F, 1'b1}, // R7
    '{4'd7,  4'h7, 14'h0000, 14'h0000, 14'h0000, 1'b0, 14'h0000, 1'b1}, // R7
    '{4'd7,  4'h7, 14'h3FFF, 14'h3FFF, 14'h0000, 1'b0, 14'h3FFF, 1'b1}, // R7
    '{4'd8,  4'h8, 14'h0000, 14'h0000, 14'h0000, 1'b0, 14'h2AAA, 1'b1}, // R8
    '{4'd8,  4'h9, 14'h0000, 14'h0000, 14'h0000, 1'b0, 14'h3FFF, 1'b1}, // R8
    '{4'd9,  4'h5, 14'h1234, 14'h0000, 14'h0555, 1'b1, 14'h0555, 1'b1}, // R9
    '{4'd9,  4'hF, 14'h1234, 14'h0000, 14'h2222, 1'b0, 14'h2222, 1'b0}, // R9
    '{4'd9,  4'hA, 14'h1234, 14'h0000, 14'h1111, 1'b1, 14'h1111, 1'b1}, // R9
    '{4'd4,  4'h4, 14'h0000, 14'h0000, 14'h0000, 1'b0, 14'h0000, 1'b1}, // R4 re-entry
    '{4'd4,  4'h4, 14'h0000, 14'h0000, 14'h0000, 1'b0, 14'h0001, 1'b1}, // R4
    '{4'd3,  4'h3, 14'h0000, 14'h0000, 14'h0000, 1'b0, 14'h2AAA, 1'b1}, // R3 restart
    '{4'd7,  4'h7, 14'h0101, 14'h0202, 14'h0000, 1'b0, 14'h0101, 1'b1}, // R7 restart
    '{4'd7,  4'h7, 14'h0101, 14'h0202, 14'h0000, 1'b0, 14'h0202, 1'b1}  // R7
  };

  logic        clk;
  logic        rst_n;
  logic [3:0]  mode_code;
  logic [13:0] cust_word_a;
  logic [13:0] cust_word_b;
  logic [13:0] live_data;
  logic        live_vld;
  logic [13:0] out_data;
  logic        out_vld;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  tpg_top u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_code   (mode_code),
    .cust_word_a (cust_word_a),
    .cust_word_b (cust_word_b),
    .live_data   (live_data),
    .live_vld    (live_vld),
    .out_data    (out_data),
    .out_vld     (out_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles >= 100000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual cycles=%0d expected below 100000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input int req, input logic [13:0] ad, input logic [13:0] ed,
                       input logic av, input logic ev);
    total++;
    if (ad !== ed || av !== ev) begin
      bad++;
      $display("FAIL R%0d: actual data=%h vld=%b expected data=%h vld=%b", req, ad, av, ed, ev);
    end
  endtask

  task automatic drive(input logic [3:0] m, input logic [13:0] a, input logic [13:0] b,
                       input logic [13:0] l, input logic lv);
    mode_code   = m;
    cust_word_a = a;
    cust_word_b = b;
    live_data   = l;
    live_vld    = lv;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(4'h0, 14'h0, 14'h0, 14'h1FFF, 1'b1);
    drive(4'h4, 14'h0, 14'h0, 14'h1FFF, 1'b1);
    check(10, out_data, 14'h0000, out_vld, 1'b0); // R10 held in reset
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].mode, VECS[i].ca, VECS[i].cb, VECS[i].live, VECS[i].lv);
      check(int'(VECS[i].req), out_data, VECS[i].ed, out_vld, VECS[i].ev);
    end

    // R10: asynchronous reset mid-stream, then ramp restarts at zero
    drive(4'h4, 14'h0, 14'h0, 14'h0, 1'b0);
    drive(4'h4, 14'h0, 14'h0, 14'h0, 1'b0);
    rst_n = 1'b0;
    #1;
    check(10, out_data, 14'h0000, out_vld, 1'b0); // R10
    @(negedge clk);
    rst_n = 1'b1;
    drive(4'h4, 14'h0, 14'h0, 14'h0, 1'b0);
    check(10, out_data, 14'h0000, out_vld, 1'b1); // R10 first ramp word

    // R5 / R4 / R11: full ramp pass with wrap; strobe toggles, valid stays high
    for (int i = 1; i <= 16385; i++) begin
      drive(4'h4, 14'h0, 14'h0, 14'h0, i[0]);
      if (i == 16383)      check(5, out_data, 14'h3FFF, out_vld, 1'b1); // R5 top code
      else if (i == 16384) check(5, out_data, 14'h0000, out_vld, 1'b1); // R5 wrap
      else                 check(4, out_data, 14'(i), out_vld, 1'b1);   // R4 R11
    end

    // R7: equal all-ones words held over several clocks
    for (int i = 0; i < 4; i++) begin
      drive(4'h7, 14'h3FFF, 14'h3FFF, 14'h0, 1'b0);
      check(7, out_data, 14'h3FFF, out_vld, 1'b1); // R7
    end
    // R7: equal all-zero words
    for (int i = 0; i < 4; i++) begin
      drive(4'h7, 14'h0000, 14'h0000, 14'h0, 1'b0);
      check(7, out_data, 14'h0000, out_vld, 1'b1); // R7
    end
    // R1 after test modes: strobe passed low again
    drive(4'h0, 14'h0, 14'h0, 14'h2ABC, 1'b0);
    check(1, out_data, 14'h2ABC, out_vld, 1'b0); // R1

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule